// File: doc/BRIEF.md
# Host PIO Burst Read Sequencer

This block sits on the host side of a 32-bit asynchronous parallel slave bus and turns a single read command into a burst of word reads. The command gives a start word address and a beat count. The block then lowers the active-low chip-select and read strobes and walks the word address upward, one 32-bit word per beat. It latches the data bus once per beat and returns every word on a response stream with a one-cycle valid strobe.

The slave counts a cycle as open only while both strobes are low, and gives new data each time word-address bit 0 changes (byte-address bit 2). The slave sets several timing limits, which are given in picoseconds and rounded up to whole cycles of the clock period parameter:
- how long each address must be held;
- how long after an address change, and after the strobes fall, the data becomes valid;
- how long the strobes must stay high between two strobe windows.

The block takes each sample at the later of the two data-valid points. It closes the strobe window and reopens it after the minimum high time whenever a burst crosses an aligned eight-word group. A done pulse marks the end of each command.

Top module: `pio_burst_reader`

## Requirements
- R1: During and directly after reset, both strobes are high, the bus address is zero, and rsp_valid and done are low.
- R2: req_ready is high only when no command is running, the minimum strobe high time has passed and the current address has been held for the address cycle time. A request made while busy is ignored and starts no strobe window. So is a request with length zero.
- R3: A strobe window opens with chip-select and read strobe falling on the same edge, and closes with both rising on the same edge.
- R4: Inside one strobe window, each address change is an increment of exactly one word. A window never steps past a word whose three low address bits are 111, so no window spans two aligned eight-word groups.
- R5: Every address change comes at least 45 ns after the previous address change.
- R6: Each word is sampled at least 40 ns after its address was set and at least 30 ns after the strobes fell, always inside the window. The word returned is the bus value for that address.
- R7: Between the rising and the next falling of the strobes, at least 13 ns pass.
- R8: A command with start address A and length N returns exactly N words, for addresses A, A+1, …, A+N-1, in that order, one per rsp_valid cycle.
- R9: done is high for exactly one cycle, in the cycle after the last word's rsp_valid.
- R10: The word address wraps modulo 2^ADDR_W. A burst that passes the top address continues at address zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request |
| req_ready | output | 1 | Command can be accepted this cycle |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Number of words to read |
| bus_cs_n | output | 1 | Active-low chip select |
| bus_rd_n | output | 1 | Active-low read strobe |
| bus_addr | output | ADDR_W | Word address on the bus |
| bus_data | input | DATA_W | Read data from the slave |
| rsp_valid | output | 1 | rsp_data holds a new word |
| rsp_data | output | DATA_W | Returned word |
| done | output | 1 | Command finished |

## Verification
The assertions assume that the host offers commands only through the req_valid/req_ready handshake. They also assume that bus_data is not needed to be valid outside the slave's timing windows. The bench's slave model makes that second point sharp: it drives a poison value whenever the strobes are high or the address or strobe age is below the data-valid times in nanoseconds. Any sample taken too early therefore shows up as a wrong word. The stimulus asserts req_valid only as a one-cycle handshake after seeing req_ready, plus short deliberate pulses while a burst runs and with length zero. Start addresses sweep every position inside an eight-word group and several lengths, including wrap past the top address.

// File: rtl/pio_burst_pkg.sv
package pio_burst_pkg;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_GAP  = 2'd2,
      ST_FIN  = 2'd3
   } pio_state_e;

   // Round a time in ps up to whole clock cycles, at least one.
   function automatic int unsigned ps_to_cycles(input int unsigned t_ps,
                                                input int unsigned clk_ps);
      int unsigned c;
      c = (t_ps + clk_ps - 1) / clk_ps;
      return (c == 0) ? 1 : c;
   endfunction

   function automatic int unsigned max_u(input int unsigned a,
                                         input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pio_age_counter.sv
// Saturating age counter: reset to zero by clr, counts clock edges since.
module pio_age_counter #(
   parameter int unsigned MAX_VAL = 7,
   localparam int unsigned W      = $clog2(MAX_VAL + 1)
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   output logic [W-1:0] age
);

   localparam logic [W-1:0] LIMIT = W'(MAX_VAL);

   logic [W-1:0] age_q;

   generate
      if (MAX_VAL == 1) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n || clr) age_q <= '0;
            else               age_q <= 1'b1;
         end
      end else begin : g_count
         always_ff @(posedge clk) begin
            if (!rst_n || clr)       age_q <= '0;
            else if (age_q != LIMIT) age_q <= age_q + 1'b1;
         end
      end
   endgenerate

   assign age = age_q;

endmodule

// File: rtl/pio_word_capture.sv
// Data latch: registers the bus word on the sampling edge.
module pio_word_capture #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap_en,
   input  logic [DATA_W-1:0] bus_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= cap_en;
         if (cap_en) rsp_data <= bus_data;
      end
   end

endmodule

// File: rtl/pio_burst_ctrl.sv
// Sequencer: strobe windows, address stepping, sample timing.
module pio_burst_ctrl
   import pio_burst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned LEN_W       = 6,
   parameter int unsigned BURST_WORDS = 8,
   parameter int unsigned ACYC_C      = 6,
   parameter int unsigned ADV_C       = 5,
   parameter int unsigned CSDV_C      = 4,
   parameter int unsigned CSH_C       = 2,
   parameter int unsigned BEAT_W      = 3,
   parameter int unsigned STR_W       = 3,
   parameter int unsigned HIGH_W      = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              req_ready,
   input  logic [BEAT_W-1:0] beat_age,
   input  logic [STR_W-1:0]  strobe_age,
   input  logic [HIGH_W-1:0] high_age,
   output logic              clr_beat,
   output logic              clr_strobe,
   output logic              clr_high,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic [ADDR_W-1:0] bus_addr,
   output logic              cap_en,
   output logic              done
);

   localparam int unsigned BLK_BITS = $clog2(BURST_WORDS);
   localparam logic [BEAT_W-1:0] ACYC_T = BEAT_W'(ACYC_C - 1);
   localparam logic [BEAT_W-1:0] ADV_T  = BEAT_W'(ADV_C - 1);
   localparam logic [STR_W-1:0]  CSDV_T = STR_W'(CSDV_C - 1);
   localparam logic [HIGH_W-1:0] CSH_T  = HIGH_W'(CSH_C - 1);

   pio_state_e        state_q;
   logic              cs_q, rd_q, sampled_q, done_q;
   logic [ADDR_W-1:0] addr_q;
   logic [LEN_W-1:0]  left_q;

   logic high_ok, hold_ok, accept, sample, step, reopen, last_word, at_edge;

   generate
      if (BLK_BITS == 0) begin : g_single
         assign at_edge = 1'b1;
      end else begin : g_group
         assign at_edge = &addr_q[BLK_BITS-1:0];
      end
   endgenerate

   always_comb begin
      high_ok   = (high_age >= CSH_T);
      hold_ok   = (beat_age >= ACYC_T);
      req_ready = (state_q == ST_IDLE) && high_ok && hold_ok;
      accept    = req_ready && req_valid && (req_len != '0);
      sample    = (state_q == ST_RUN) && !sampled_q &&
                  (beat_age >= ADV_T) && (strobe_age >= CSDV_T);
      step      = (state_q == ST_RUN) && sampled_q && hold_ok;
      reopen    = (state_q == ST_GAP) && high_ok && hold_ok;
      last_word = (left_q == LEN_W'(1));
      clr_beat   = accept || step || reopen;
      clr_strobe = accept || reopen;
      clr_high   = sample && (last_word || at_edge);
      cap_en     = sample;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_IDLE;
         cs_q      <= 1'b1;
         rd_q      <= 1'b1;
         addr_q    <= '0;
         left_q    <= '0;
         sampled_q <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= (state_q == ST_FIN);
         unique case (state_q)
            ST_IDLE: begin
               if (accept) begin
                  addr_q    <= req_addr;
                  left_q    <= req_len;
                  cs_q      <= 1'b0;
                  rd_q      <= 1'b0;
                  sampled_q <= 1'b0;
                  state_q   <= ST_RUN;
               end
            end
            ST_RUN: begin
               if (sample) begin
                  sampled_q <= 1'b1;
                  left_q    <= left_q - 1'b1;
                  if (last_word) begin
                     cs_q    <= 1'b1;
                     rd_q    <= 1'b1;
                     state_q <= ST_FIN;
                  end else if (at_edge) begin
                     cs_q    <= 1'b1;
                     rd_q    <= 1'b1;
                     state_q <= ST_GAP;
                  end
               end else if (step) begin
                  addr_q    <= addr_q + 1'b1;
                  sampled_q <= 1'b0;
               end
            end
            ST_GAP: begin
               if (reopen) begin
                  addr_q    <= addr_q + 1'b1;
                  cs_q      <= 1'b0;
                  rd_q      <= 1'b0;
                  sampled_q <= 1'b0;
                  state_q   <= ST_RUN;
               end
            end
            ST_FIN: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign bus_cs_n = cs_q;
   assign bus_rd_n = rd_q;
   assign bus_addr = addr_q;
   assign done     = done_q;

   // R5: an address change only once the hold counter has run out
   assert_addr_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (addr_q != $past(addr_q)) |-> ($past(beat_age) >= ACYC_T));

   // R4: inside an open window the address moves by one word
   assert_step_one_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_q && $past(!cs_q) && (addr_q != $past(addr_q)))
      |-> (addr_q == $past(addr_q) + 1'b1));

   // R4: no step inside a window past the last word of a group
   assert_no_group_cross_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cs_q && $past(!cs_q) && (addr_q != $past(addr_q)))
      |-> ($past(at_edge) == 1'b0));

   // R7: strobes fall only after the minimum high time
   assert_high_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cs_q) |-> ($past(high_age) >= CSH_T));

   // R2: ready only while the strobes are high
   assert_ready_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (cs_q && rd_q));

endmodule

// File: rtl/pio_burst_reader.sv
// Top: PIO burst read sequencer for a 32-bit asynchronous slave bus.
module pio_burst_reader
   import pio_burst_pkg::*;
#(
   parameter int unsigned ADDR_W      = 12,
   parameter int unsigned LEN_W       = 6,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BURST_WORDS = 8,
   parameter int unsigned CLK_PS      = 8000,
   parameter int unsigned T_ACYC_PS   = 45000,
   parameter int unsigned T_ADV_PS    = 40000,
   parameter int unsigned T_CSDV_PS   = 30000,
   parameter int unsigned T_CSH_PS    = 13000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [LEN_W-1:0]  req_len,
   output logic              bus_cs_n,
   output logic              bus_rd_n,
   output logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_data,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_data,
   output logic              done
);

   localparam int unsigned ACYC_C = ps_to_cycles(T_ACYC_PS, CLK_PS);
   localparam int unsigned ADV_C  = ps_to_cycles(T_ADV_PS, CLK_PS);
   localparam int unsigned CSDV_C = ps_to_cycles(T_CSDV_PS, CLK_PS);
   localparam int unsigned CSH_C  = ps_to_cycles(T_CSH_PS, CLK_PS);
   localparam int unsigned BEAT_MAX = max_u(ACYC_C, ADV_C);
   localparam int unsigned BEAT_W = $clog2(BEAT_MAX + 1);
   localparam int unsigned STR_W  = $clog2(CSDV_C + 1);
   localparam int unsigned HIGH_W = $clog2(CSH_C + 1);

   generate
      if ((BURST_WORDS == 0) || ((BURST_WORDS & (BURST_WORDS - 1)) != 0)) begin : g_bad_group
         $error("BURST_WORDS must be a power of two");
      end
      if ((1 << ADDR_W) < BURST_WORDS) begin : g_bad_addr
         $error("ADDR_W too narrow for BURST_WORDS");
      end
      if (LEN_W < 1 || CLK_PS == 0) begin : g_bad_misc
         $error("LEN_W and CLK_PS must be non-zero");
      end
   endgenerate

   logic [BEAT_W-1:0] beat_age;
   logic [STR_W-1:0]  strobe_age;
   logic [HIGH_W-1:0] high_age;
   logic clr_beat, clr_strobe, clr_high, cap_en;

   pio_age_counter #(.MAX_VAL(BEAT_MAX)) u_beat_age (
      .clk(clk), .rst_n(rst_n), .clr(clr_beat), .age(beat_age));

   pio_age_counter #(.MAX_VAL(CSDV_C)) u_strobe_age (
      .clk(clk), .rst_n(rst_n), .clr(clr_strobe), .age(strobe_age));

   pio_age_counter #(.MAX_VAL(CSH_C)) u_high_age (
      .clk(clk), .rst_n(rst_n), .clr(clr_high), .age(high_age));

   pio_burst_ctrl #(
      .ADDR_W(ADDR_W), .LEN_W(LEN_W), .BURST_WORDS(BURST_WORDS),
      .ACYC_C(ACYC_C), .ADV_C(ADV_C), .CSDV_C(CSDV_C), .CSH_C(CSH_C),
      .BEAT_W(BEAT_W), .STR_W(STR_W), .HIGH_W(HIGH_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
      .req_ready(req_ready),
      .beat_age(beat_age), .strobe_age(strobe_age), .high_age(high_age),
      .clr_beat(clr_beat), .clr_strobe(clr_strobe), .clr_high(clr_high),
      .bus_cs_n(bus_cs_n), .bus_rd_n(bus_rd_n), .bus_addr(bus_addr),
      .cap_en(cap_en), .done(done));

   pio_word_capture #(.DATA_W(DATA_W)) u_capture (
      .clk(clk), .rst_n(rst_n), .cap_en(cap_en), .bus_data(bus_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data));

   // R6: every returned word was latched while the window was open
   assert_sample_in_window_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> ($past(bus_cs_n) == 1'b0 && $past(bus_rd_n) == 1'b0));

   // R9: done directly follows the final word
   assert_done_after_word_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(rsp_valid));

   // R9: done lasts a single cycle
   assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3: the two strobes always move together
   assert_strobes_paired_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(bus_cs_n) |-> $fell(bus_rd_n));

endmodule

// File: tb/pio_burst_reader_bench.sv
`timescale 1ns/1ps
module pio_burst_reader_bench;

   localparam int AW = 6;
   localparam int LW = 5;
   localparam int PER_NS = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [LW-1:0] req_len = '0;
   logic          bus_cs_n, bus_rd_n;
   logic [AW-1:0] bus_addr;
   logic [31:0]   bus_data = 32'hBAD0_BAD0;
   logic          rsp_valid;
   logic [31:0]   rsp_data;
   logic          done;

   always #4 clk = ~clk;

   pio_burst_reader #(.ADDR_W(AW), .LEN_W(LW), .CLK_PS(8000)) u_pio_burst_reader (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .bus_cs_n(bus_cs_n),
      .bus_rd_n(bus_rd_n), .bus_addr(bus_addr), .bus_data(bus_data),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .done(done));

   int vectors = 0;
   int miscompares = 0;
   bit finished = 0;

   function automatic logic [31:0] word_of(input logic [AW-1:0] a);
      return 32'hC3A5_0000 ^ ({26'd0, a} * 32'h0103_0507);
   endfunction

   task automatic chk(input bit ok, input string req,
                      input logic [31:0] act, input logic [31:0] exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   endtask

   // expectation state shared by driver and monitor
   logic [AW-1:0] exp_addr = '0;
   int            exp_left = 0;
   bit            got_done = 0;

   // slave model and protocol monitor, all at the falling edge
   int            addr_age = 1000, win_age = 0, hi_age = 1000;
   logic [AW-1:0] prev_addr = '0;
   bit            prev_win = 0, prev_rsp = 0, prev_done = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         automatic bit win = !bus_cs_n && !bus_rd_n;
         chk(bus_cs_n == bus_rd_n, "R3 strobes paired", {31'd0, bus_rd_n}, {31'd0, bus_cs_n});
         if (bus_addr != prev_addr) begin
            chk(addr_age * PER_NS >= 45, "R5 address hold", addr_age, 45);
            if (win && prev_win) begin
               chk(bus_addr == prev_addr + 1'b1, "R4 step one word",
                   {26'd0, bus_addr}, {26'd0, prev_addr + 1'b1});
               chk(prev_addr[2:0] != 3'b111, "R4 group split",
                   {29'd0, prev_addr[2:0]}, 32'd6);
            end
            addr_age = 1;
         end else begin
            addr_age++;
         end
         if (win && !prev_win) begin
            chk(hi_age * PER_NS >= 13, "R7 strobe high time", hi_age, 13);
            win_age = 1;
         end else if (win) begin
            win_age++;
         end
         if (!win && prev_win) hi_age = 1;
         else if (!win)        hi_age++;
         // data valid only inside the timing windows
         bus_data = (win && addr_age * PER_NS >= 40 && win_age * PER_NS >= 30)
                    ? word_of(bus_addr) : 32'hBAD0_BAD0;
         if (rsp_valid) begin
            chk(exp_left > 0, "R8 word count", exp_left, 1);
            chk(rsp_data == word_of(exp_addr), "R6 R8 word value",
                rsp_data, word_of(exp_addr));
            exp_addr = exp_addr + 1'b1;
            exp_left--;
         end
         if (done) begin
            chk(prev_rsp, "R9 done after last word", {31'd0, prev_rsp}, 1);
            chk(exp_left == 0, "R8 all words returned", exp_left, 0);
            chk(!prev_done, "R9 done single cycle", {31'd0, prev_done}, 0);
            got_done = 1;
         end
         prev_addr = bus_addr;
         prev_win  = win;
         prev_rsp  = rsp_valid;
         prev_done = done;
      end
   end

   task automatic run_burst(input int start, input int len);
      int guard;
      guard = 0;
      @(negedge clk); #1;
      while (!req_ready && guard < 100) begin @(negedge clk); #1; guard++; end
      chk(req_ready, "R2 ready when idle", {31'd0, req_ready}, 1);
      exp_addr = AW'(start);
      exp_left = len;
      got_done = 0;
      req_addr = AW'(start);
      req_len  = LW'(len);
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      repeat (2) begin @(negedge clk); #1; end
      // request while busy: must be ignored
      chk(!req_ready, "R2 not ready while busy", {31'd0, req_ready}, 0);
      req_addr = AW'(start + 17);
      req_len  = 5'd3;
      req_valid = 1'b1;
      @(negedge clk); #1;
      req_valid = 1'b0;
      guard = 0;
      while (!got_done && guard < 2000) begin @(negedge clk); #1; guard++; end
      chk(got_done, "R9 done seen", {31'd0, got_done}, 1);
      repeat (4) begin
         @(negedge clk); #1;
         chk(bus_cs_n && bus_rd_n, "R2 busy request ignored",
             {31'd0, bus_cs_n}, 1);
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(bus_cs_n && bus_rd_n, "R1 strobes high in reset", {30'd0, bus_cs_n, bus_rd_n}, 3);
      chk(bus_addr == '0, "R1 address zero", {26'd0, bus_addr}, 0);
      chk(!rsp_valid && !done, "R1 outputs low", {30'd0, rsp_valid, done}, 0);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk(bus_cs_n && bus_rd_n && bus_addr == '0 && !rsp_valid && !done,
          "R1 state after release", {26'd0, bus_addr}, 0);
      // R2: zero-length request is ignored
      repeat (6) @(negedge clk);
      #1;
      req_addr = 6'd9; req_len = '0; req_valid = 1'b1;
      repeat (4) begin
         @(negedge clk); #1;
         chk(bus_cs_n && req_ready, "R2 zero length ignored",
             {30'd0, bus_cs_n, req_ready}, 3);
      end
      req_valid = 1'b0;
      // sweep of start offsets and lengths (R4 R5 R6 R7 R8 R9)
      for (int s = 0; s < 16; s++)
         for (int n = 1; n <= 12; n++)
            run_burst(s, n);
      // R10: wrap past the top address
      run_burst(60, 8);
      run_burst(62, 12);
      run_burst(57, 20);
      // long aligned and unaligned bursts
      run_burst(0, 16);
      run_burst(7, 31);
      report();
   end

   // watchdog
   int cycles = 0;
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !finished) begin
         miscompares++;
         $display("FAIL watchdog expired actual=%0d expected=<150000", cycles);
         report();
      end
   end

endmodule